// File: doc/BRIEF.md
# Analog Power and Thermal Latch Controller

This block owns the small configuration word that decides whether the analog output stage of a high-voltage converter is running, and what the output pin does while that stage is off: float, or sink to ground through a pull-down. The serial front end hands it decoded control-word writes and marks the end of every other write frame. The block also takes a raw over-temperature signal from an on-die comparator and turns it into a latched shutdown that software has to acknowledge.

A control-word write is parked in a holding stage. It only reaches the live register when the next non-control write frame ends, whether that frame is a data write or a no-op. When the filtered temperature input shows two consecutive hot samples, the shutdown flag is set. This pulls the analog enable low and drives the active-low alarm. The flag stays set after the die has cooled, and is cleared only by a committed control write whose flag bit is zero. The live register can be read back at any time on a parallel read bus.

Top module: `pwr_thermal_ctl`

## Requirements
- R1: After reset, the readback word is 0x040, `ana_en` is 0, `out_hiz` is 1 and `alarm_n` is 1.
- R2: A control write changes neither the readback nor any output until a `frame_wr` pulse follows it. The committed value is then visible in the cycle after that pulse.
- R3: Bit 2 of the committed word is the power request. `ana_en` follows it while the shutdown flag is clear.
- R4: Bit 6 of the committed word drives `out_hiz`: 1 selects three-state and 0 selects the ground pull-down.
- R5: Bits 1, 3, 4, 5 and 11:7 of the readback are always 0, whatever value was written to them.
- R6: If `temp_hot` is seen high for two consecutive synchronised samples, readback bit 0 (the shutdown flag) is set, `alarm_n` goes low and `ana_en` goes low. This happens on the fifth rising edge after the input rises, counted from the first edge that samples it.
- R7: A `temp_hot` pulse that lasts one clock leaves the flag clear and `alarm_n` high.
- R8: The flag stays set after `temp_hot` falls. Only a committed write with bit 0 = 0 clears it. A committed write with bit 0 = 1 never sets it.
- R9: While the flag is set, `ana_en` is 0 whatever bit 2 holds. Once the flag is cleared, `ana_en` equals bit 2.
- R10: If a clearing commit lands while the filtered temperature is still hot, the trip wins and the flag stays set.
- R11: A second control write before any `frame_wr` replaces the held value, so only the last one is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | One-cycle strobe: a control-word write frame has ended |
| ctl_wdata | input | 12 | Data field of that control write |
| frame_wr | input | 1 | One-cycle strobe: a data or no-op write frame has ended |
| ctl_rdata | output | 12 | Readback of the live control word |
| temp_hot | input | 1 | Asynchronous over-temperature comparator output |
| ana_en | output | 1 | Analog section enable |
| out_hiz | output | 1 | Output mode while off: 1 three-state, 0 pull-down |
| alarm_n | output | 1 | Active-low thermal alarm |

## Verification
Two events can fall in the same clock cycle: the qualified thermal trip, and the commit of a write that clears the flag. The bench holds `temp_hot` high through a whole clear-and-commit sequence, so the clearing commit arrives while the filter still reports hot. A pass requires the flag to remain set, the alarm to stay low and the enable to stay off. A second pass with the input low then shows that the same write does clear the flag.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;

   // Positions that the readback consumer decodes
   localparam int unsigned FLAG_POS = 0;
   localparam int unsigned PWR_POS  = 2;
   localparam int unsigned HIZ_POS  = 6;
   localparam int unsigned CFG_W    = 7;

   // Live configuration held by the core
   typedef struct packed {
      logic hiz;
      logic pwr;
      logic flag;
   } live_cfg_t;

   // Value parked between a control write and its commit
   typedef struct packed {
      logic hiz;
      logic pwr;
      logic clr;
   } held_cfg_t;

   localparam live_cfg_t LIVE_RESET = '{hiz: 1'b1, pwr: 1'b0, flag: 1'b0};

   function automatic held_cfg_t unpack_word(input logic [CFG_W-1:0] w);
      held_cfg_t h;
      h.hiz = w[HIZ_POS];
      h.pwr = w[PWR_POS];
      h.clr = ~w[FLAG_POS];
      return h;
   endfunction

endpackage

// File: rtl/ot_qualifier.sv
module ot_qualifier #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned QUAL_COUNT  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic hot
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ot_qualifier: SYNC_STAGES must be at least 2");
      end
      if (QUAL_COUNT < 1) begin : g_bad_qual
         $error("ot_qualifier: QUAL_COUNT must be at least 1");
      end
   endgenerate

   localparam int unsigned CNT_W = $clog2(QUAL_COUNT + 1);

   logic [SYNC_STAGES-1:0] chain;
   logic                   sampled;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[SYNC_STAGES-2:0], async_in};
      end
   end

   assign sampled = chain[SYNC_STAGES-1];

   generate
      if (QUAL_COUNT == 1) begin : g_single
         logic hot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hot_q <= 1'b0;
            else        hot_q <= sampled;
         end
         assign hot = hot_q;
      end else begin : g_count
         logic [CNT_W-1:0] run_len;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_len <= '0;
            end else if (!sampled) begin
               run_len <= '0;
            end else if (run_len != CNT_W'(QUAL_COUNT)) begin
               run_len <= run_len + CNT_W'(1);
            end
         end
         assign hot = (run_len == CNT_W'(QUAL_COUNT));

         // R7: a qualified trip needs the two preceding samples to be hot
         a_r7_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hot) |-> ($past(sampled) && $past(sampled, 2)));
      end
   endgenerate

   // R7: hot never survives two quiet samples
   a_r7_drops_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!sampled && $past(!sampled)) |-> !hot);

endmodule

// File: rtl/ctl_stage.sv
module ctl_stage
   import pwr_ctl_pkg::*;
#(
   parameter int unsigned DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] ctl_wdata,
   input  logic              frame_wr,
   output logic              commit,
   output held_cfg_t         commit_cfg
);

   generate
      if (DATA_W < CFG_W) begin : g_bad_width
         $error("ctl_stage: DATA_W must cover the control field");
      end
   endgenerate

   logic      held_valid;
   held_cfg_t held;
   logic      unused_rsvd_bits;

   // Reserved positions are discarded on entry
   assign unused_rsvd_bits = ^{ctl_wdata[DATA_W-1:CFG_W],
                               ctl_wdata[5:3], ctl_wdata[1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_valid <= 1'b0;
         held       <= '0;
      end else if (ctl_wr) begin
         held_valid <= 1'b1;
         held       <= unpack_word(ctl_wdata[CFG_W-1:0]);
      end else if (frame_wr) begin
         held_valid <= 1'b0;
      end
   end

   assign commit     = frame_wr && held_valid && !ctl_wr;
   assign commit_cfg = held;

   // R2: a commit consumes the held value
   a_r2_commit_consumes: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !held_valid);

   // R11: a later write refreshes the held word without committing
   a_r11_rewrite_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> held_valid);

endmodule

// File: rtl/ctl_core.sv
module ctl_core
   import pwr_ctl_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      commit,
   input  held_cfg_t commit_cfg,
   input  logic      hot,
   output live_cfg_t live
);

   live_cfg_t live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= LIVE_RESET;
      end else begin
         if (commit) begin
            live_q.pwr <= commit_cfg.pwr;
            live_q.hiz <= commit_cfg.hiz;
         end
         if (hot) begin
            live_q.flag <= 1'b1;
         end else if (commit && commit_cfg.clr) begin
            live_q.flag <= 1'b0;
         end
      end
   end

   assign live = live_q;

   // R6: a qualified trip sets the flag on the next edge
   a_r6_trip_sets: assert property (@(posedge clk) disable iff (!rst_n)
      hot |=> live_q.flag);

   // R8: the flag leaves only through a clearing commit
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q.flag && !(commit && commit_cfg.clr)) |=> live_q.flag);

   // R8: nothing but a trip raises the flag
   a_r8_no_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!live_q.flag && !hot) |=> !live_q.flag);

   // R10: trip and clearing commit together leave the flag set
   a_r10_trip_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (hot && commit && commit_cfg.clr) |=> live_q.flag);

   // R2: mode bits move only on a commit
   a_r2_stable_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(live_q.pwr) && $stable(live_q.hiz)));

endmodule

// File: rtl/pwr_thermal_ctl.sv
module pwr_thermal_ctl
   import pwr_ctl_pkg::*;
#(
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned QUAL_COUNT  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] ctl_wdata,
   input  logic              frame_wr,
   output logic [DATA_W-1:0] ctl_rdata,
   input  logic              temp_hot,
   output logic              ana_en,
   output logic              out_hiz,
   output logic              alarm_n
);

   logic      hot;
   logic      commit;
   held_cfg_t commit_cfg;
   live_cfg_t live;

   ot_qualifier #(
      .SYNC_STAGES (SYNC_STAGES),
      .QUAL_COUNT  (QUAL_COUNT)
   ) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (temp_hot),
      .hot      (hot)
   );

   ctl_stage #(
      .DATA_W (DATA_W)
   ) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_wr     (ctl_wr),
      .ctl_wdata  (ctl_wdata),
      .frame_wr   (frame_wr),
      .commit     (commit),
      .commit_cfg (commit_cfg)
   );

   ctl_core u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit     (commit),
      .commit_cfg (commit_cfg),
      .hot        (hot),
      .live       (live)
   );

   always_comb begin
      ctl_rdata           = '0;
      ctl_rdata[FLAG_POS] = live.flag;
      ctl_rdata[PWR_POS]  = live.pwr;
      ctl_rdata[HIZ_POS]  = live.hiz;
   end

   assign ana_en  = live.pwr & ~live.flag;
   assign out_hiz = live.hiz;
   assign alarm_n = ~live.flag;

   // R9: the analog section is off whenever the alarm is active
   a_r9_off_in_alarm: assert property (@(posedge clk) disable iff (!rst_n)
      !alarm_n |-> !ana_en);

   // R6: the alarm pin and the readback flag agree
   a_r6_alarm_matches_flag: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_n == !ctl_rdata[FLAG_POS]);

endmodule

// File: tb/pwr_thermal_ctl_test.sv
`timescale 1ns/1ps
module pwr_thermal_ctl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [11:0] ctl_wdata = '0;
   logic        frame_wr = 1'b0;
   logic [11:0] ctl_rdata;
   logic        temp_hot = 1'b0;
   logic        ana_en, out_hiz, alarm_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwr_thermal_ctl uut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .frame_wr(frame_wr), .ctl_rdata(ctl_rdata), .temp_hot(temp_hot),
      .ana_en(ana_en), .out_hiz(out_hiz), .alarm_n(alarm_n)
   );

   task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%03h expected=0x%03h", req, got, exp);
      end
   endtask

   task automatic ctl_write(input logic [11:0] w);
      @(negedge clk);
      ctl_wr = 1'b1; ctl_wdata = w;
      @(negedge clk);
      ctl_wr = 1'b0; ctl_wdata = '0;
   endtask

   task automatic frame_end();
      @(negedge clk);
      frame_wr = 1'b1;
      @(negedge clk);
      frame_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 readback", ctl_rdata, 12'h040);
      check("R1 ana_en", {11'b0, ana_en}, 12'h000);
      check("R1 out_hiz", {11'b0, out_hiz}, 12'h001);
      check("R1 alarm_n", {11'b0, alarm_n}, 12'h001);
   endtask

   task automatic t_staged_commit();
      ctl_write(12'h004);
      idle(3);
      check("R2 held readback", ctl_rdata, 12'h040);
      check("R2 held ana_en", {11'b0, ana_en}, 12'h000);
      frame_end();
      check("R2 committed", ctl_rdata, 12'h004);
      check("R3 power up", {11'b0, ana_en}, 12'h001);
      check("R4 pull-down", {11'b0, out_hiz}, 12'h000);
   endtask

   task automatic t_reserved();
      ctl_write(12'hFFE);
      frame_end();
      check("R5 reserved zero", ctl_rdata, 12'h044);
      check("R4 three-state", {11'b0, out_hiz}, 12'h001);
      ctl_write(12'h041);
      frame_end();
      check("R8 no soft set", ctl_rdata, 12'h040);
      check("R8 alarm idle", {11'b0, alarm_n}, 12'h001);
      check("R3 power down", {11'b0, ana_en}, 12'h000);
   endtask

   task automatic t_replace();
      ctl_write(12'h040);
      ctl_write(12'h004);
      frame_end();
      check("R11 last write wins", ctl_rdata, 12'h004);
      ctl_write(12'h044);
      frame_end();
      check("R11 setup", ctl_rdata, 12'h044);
   endtask

   task automatic t_glitch();
      @(negedge clk); temp_hot = 1'b1;
      @(negedge clk); temp_hot = 1'b0;
      idle(8);
      check("R7 glitch alarm", {11'b0, alarm_n}, 12'h001);
      check("R7 glitch readback", ctl_rdata, 12'h044);
   endtask

   task automatic t_trip();
      @(negedge clk); temp_hot = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R6 not before fifth edge", {11'b0, alarm_n}, 12'h001);
      @(posedge clk);
      @(negedge clk);
      check("R6 alarm low", {11'b0, alarm_n}, 12'h000);
      check("R6 flag readback", ctl_rdata, 12'h045);
      check("R9 forced off", {11'b0, ana_en}, 12'h000);
   endtask

   task automatic t_collision();
      ctl_write(12'h044);
      frame_end();
      check("R10 flag kept", ctl_rdata, 12'h045);
      check("R10 alarm kept", {11'b0, alarm_n}, 12'h000);
      check("R10 still off", {11'b0, ana_en}, 12'h000);
   endtask

   task automatic t_sticky();
      @(negedge clk); temp_hot = 1'b0;
      idle(10);
      check("R8 sticky alarm", {11'b0, alarm_n}, 12'h000);
      ctl_write(12'h005);
      frame_end();
      check("R8 write one keeps", ctl_rdata, 12'h005);
      check("R9 off despite bit 2", {11'b0, ana_en}, 12'h000);
      ctl_write(12'h004);
      frame_end();
      check("R8 cleared", ctl_rdata, 12'h004);
      check("R8 alarm released", {11'b0, alarm_n}, 12'h001);
      check("R9 power back", {11'b0, ana_en}, 12'h001);
   endtask

   task automatic t_clear_powered_down();
      @(negedge clk); temp_hot = 1'b1;
      idle(8);
      @(negedge clk); temp_hot = 1'b0;
      idle(4);
      ctl_write(12'h040);
      frame_end();
      check("R9 clear with bit 2 low", {11'b0, ana_en}, 12'h000);
      check("R9 readback", ctl_rdata, 12'h040);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_staged_commit();
      t_reserved();
      t_replace();
      t_glitch();
      t_trip();
      t_collision();
      t_sticky();
      t_clear_powered_down();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule